// File: doc/BRIEF.md
# Background Channel Self-Test Sequencer

This block supervises a bank of general-purpose digital I/O channels without interfering with them. A single shared test comparator is steered round-robin across the channels through a select output. After each switch the block waits a fixed settle time, then compares the comparator's reading with what the channel should show. For a channel set as an input, that is the read data. For a channel set as an output, it is the level software wrote. A disagreement latches a per-channel fault bit.

Alongside the scan, the block watches every channel's read-back level. It latches rising and falling transitions in two separate status words. It also times any output channel whose sensed level differs from its driven level, and flags over-current once the mismatch outlasts a configurable limit: the clock frequency in MHz times the timeout in microseconds, 4000 cycles with the defaults. All four status words are sticky and write-one-to-clear. Each has its own interrupt mask, and one interrupt line merges them. A single enable starts and stops the whole test.

Top module: `chan_bit_monitor`

## Requirements
- R1: After reset all four status words are zero, `irq` is 0 and `cmp_sel` is 0.
- R2: While `bit_en` is 1, `cmp_sel` visits channels 0,1,…,NCH-1 and wraps to 0, staying on each for exactly SETTLE clock cycles. While `bit_en` is 0, `cmp_sel` is 0 and the dwell restarts from its beginning when `bit_en` returns.
- R3: In the last cycle of a dwell on channel s, the expected level is `ch_out[s]` if `ch_dir[s]` is 1 (output), otherwise `ch_in[s]` (input). If `cmp_in` differs from it, `fault_st[s]` is set at the next clock edge.
- R4: With `bit_en` 1, `ch_in[i]` at 0 in one cycle and 1 in the next sets `rise_st[i]`. At 1 then 0, it sets `fall_st[i]`. Both are recorded for input and output channels alike.
- R5: If `bit_en` is 1, `ch_dir[i]` is 1 and `ch_in[i]` differs from `ch_out[i]` for more than LIMIT = CLK_MHZ*OC_US consecutive cycles, `oc_st[i]` is set at the edge ending cycle LIMIT+1 of the run. Any cycle without that mismatch restarts the count.
- R6: Status bits stay set until a 1 is written on the matching bit of `clr_fault`, `clr_rise`, `clr_fall` or `clr_oc`. A new event in the same cycle as its clear leaves the bit set.
- R7: While `bit_en` is 0 no status bit is newly set, and the status words keep their values except for clears.
- R8: `irq` is 1 exactly when some status bit is 1 together with the same bit of its mask (`ie_fault`, `ie_rise`, `ie_fall`, `ie_oc`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Self-test enable |
| ch_dir | input | NCH | Per-channel direction, 1 = output |
| ch_out | input | NCH | Level written to each channel |
| ch_in | input | NCH | Level read back from each channel |
| cmp_in | input | 1 | Shared comparator reading of the selected channel |
| ie_fault | input | NCH | Interrupt mask for compare faults |
| ie_rise | input | NCH | Interrupt mask for rising transitions |
| ie_fall | input | NCH | Interrupt mask for falling transitions |
| ie_oc | input | NCH | Interrupt mask for over-current |
| clr_fault | input | NCH | Write-one-to-clear for compare faults |
| clr_rise | input | NCH | Write-one-to-clear for rising transitions |
| clr_fall | input | NCH | Write-one-to-clear for falling transitions |
| clr_oc | input | NCH | Write-one-to-clear for over-current |
| cmp_sel | output | log2(NCH) | Channel the comparator is steered to |
| fault_st | output | NCH | Latched compare faults |
| rise_st | output | NCH | Latched rising transitions |
| fall_st | output | NCH | Latched falling transitions |
| oc_st | output | NCH | Latched over-current |
| irq | output | 1 | Merged masked interrupt |

## Verification
A wrong select or dwell count shows on `cmp_sel` within one cycle, because the reference model predicts the select on every clock. A bad compare target shows on `fault_st` at the end of the affected dwell, at most one full sweep (NCH*SETTLE cycles) later. An over-current counter that misses a restart, or counts one cycle off, moves the `oc_st` edge, and the bench pins that edge to the exact cycle. Faulty edge memory or clear priority appears in `rise_st`/`fall_st` on the cycle after the stimulus.

// File: rtl/chan_bit_pkg.sv
package chan_bit_pkg;
  localparam int NKIND = 4;
  typedef enum int {K_FAULT = 0, K_RISE = 1, K_FALL = 2, K_OC = 3} stat_kind_e;

  function automatic int oc_cycles(input int clk_mhz, input int timeout_us);
    return clk_mhz * timeout_us;
  endfunction
endpackage

// File: rtl/chan_bit_rst_sync.sv
module chan_bit_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_s = s2_q;
endmodule

// File: rtl/chan_bit_scan.sv
module chan_bit_scan #(
  parameter int NCH    = 16,
  parameter int SETTLE = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               en,
  input  logic [NCH-1:0]                     ch_dir,
  input  logic [NCH-1:0]                     ch_out,
  input  logic [NCH-1:0]                     ch_in,
  input  logic                               cmp_in,
  output logic [(NCH>1?$clog2(NCH):1)-1:0]   sel,
  output logic [NCH-1:0]                     fault_set
);
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int DW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SEL_LAST   = SW'(NCH - 1);
  localparam logic [DW-1:0] DWELL_LAST = DW'(SETTLE - 1);

  logic [SW-1:0] sel_q, sel_n;
  logic [DW-1:0] dwell_q, dwell_n;
  logic          last_cyc;
  logic          expect_lvl;

  always_comb begin
    last_cyc   = en && (dwell_q == DWELL_LAST);
    expect_lvl = ch_dir[sel_q] ? ch_out[sel_q] : ch_in[sel_q];
    fault_set  = '0;
    if (last_cyc && (cmp_in != expect_lvl)) fault_set[sel_q] = 1'b1;
    if (!en) begin
      sel_n   = '0;
      dwell_n = '0;
    end else if (last_cyc) begin
      sel_n   = (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
      dwell_n = '0;
    end else begin
      sel_n   = sel_q;
      dwell_n = dwell_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      dwell_q <= '0;
    end else begin
      sel_q   <= sel_n;
      dwell_q <= dwell_n;
    end
  end

  assign sel = sel_q;

  p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_q) < NCH);

  p_sel_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_cyc |=> (sel_q == (($past(sel_q) == SEL_LAST) ? '0 : $past(sel_q) + 1'b1)));

  p_dwell_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !last_cyc) |=> $stable(sel_q));

  p_one_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_set));
endmodule

// File: rtl/chan_bit_edge.sv
module chan_bit_edge #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [NCH-1:0] ch_in,
  output logic [NCH-1:0] rise_set,
  output logic [NCH-1:0] fall_set
);
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= ch_in;
  end

  always_comb begin
    rise_set = en ? (ch_in & ~prev_q) : '0;
    fall_set = en ? (~ch_in & prev_q) : '0;
  end

  p_edge_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_set & fall_set) == '0);
endmodule

// File: rtl/chan_bit_oc.sv
module chan_bit_oc #(
  parameter int NCH   = 16,
  parameter int LIMIT = 4000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [NCH-1:0] ch_dir,
  input  logic [NCH-1:0] ch_out,
  input  logic [NCH-1:0] ch_in,
  output logic [NCH-1:0] oc_set
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

  logic [NCH-1:0] mism;

  assign mism = {NCH{en}} & ch_dir & (ch_in ^ ch_out);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cnt_q, cnt_n;
    logic          at_max;

    always_comb begin
      at_max    = (cnt_q == CNT_MAX);
      oc_set[i] = mism[i] && at_max;
      if (!mism[i])    cnt_n = '0;
      else if (at_max) cnt_n = cnt_q;
      else             cnt_n = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_n;
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);

    p_oc_prior_r5: assert property (@(posedge clk) disable iff (!rst_n)
      oc_set[i] |-> $past(mism[i]));

    p_cnt_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mism[i] |=> (cnt_q == '0));
  end
endmodule

// File: rtl/chan_bit_monitor.sv
module chan_bit_monitor #(
  parameter int NCH     = 16,
  parameter int SETTLE  = 4,
  parameter int CLK_MHZ = 50,
  parameter int OC_US   = 80
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bit_en,
  input  logic [NCH-1:0]                   ch_dir,
  input  logic [NCH-1:0]                   ch_out,
  input  logic [NCH-1:0]                   ch_in,
  input  logic                             cmp_in,
  input  logic [NCH-1:0]                   ie_fault,
  input  logic [NCH-1:0]                   ie_rise,
  input  logic [NCH-1:0]                   ie_fall,
  input  logic [NCH-1:0]                   ie_oc,
  input  logic [NCH-1:0]                   clr_fault,
  input  logic [NCH-1:0]                   clr_rise,
  input  logic [NCH-1:0]                   clr_fall,
  input  logic [NCH-1:0]                   clr_oc,
  output logic [(NCH>1?$clog2(NCH):1)-1:0] cmp_sel,
  output logic [NCH-1:0]                   fault_st,
  output logic [NCH-1:0]                   rise_st,
  output logic [NCH-1:0]                   fall_st,
  output logic [NCH-1:0]                   oc_st,
  output logic                             irq
);
  import chan_bit_pkg::*;

  localparam int OC_LIMIT = oc_cycles(CLK_MHZ, OC_US);

  logic rst_s;
  logic [NKIND-1:0][NCH-1:0] set_v, clr_v, ie_v, st_q, st_n;

  chan_bit_rst_sync u_rst (
    .clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_s)
  );

  chan_bit_scan #(.NCH(NCH), .SETTLE(SETTLE)) u_scan (
    .clk(clk), .rst_n(rst_s), .en(bit_en), .ch_dir(ch_dir), .ch_out(ch_out),
    .ch_in(ch_in), .cmp_in(cmp_in), .sel(cmp_sel), .fault_set(set_v[K_FAULT])
  );

  chan_bit_edge #(.NCH(NCH)) u_edge (
    .clk(clk), .rst_n(rst_s), .en(bit_en), .ch_in(ch_in),
    .rise_set(set_v[K_RISE]), .fall_set(set_v[K_FALL])
  );

  chan_bit_oc #(.NCH(NCH), .LIMIT(OC_LIMIT)) u_oc (
    .clk(clk), .rst_n(rst_s), .en(bit_en), .ch_dir(ch_dir), .ch_out(ch_out),
    .ch_in(ch_in), .oc_set(set_v[K_OC])
  );

  assign clr_v[K_FAULT] = clr_fault;
  assign clr_v[K_RISE]  = clr_rise;
  assign clr_v[K_FALL]  = clr_fall;
  assign clr_v[K_OC]    = clr_oc;
  assign ie_v[K_FAULT]  = ie_fault;
  assign ie_v[K_RISE]   = ie_rise;
  assign ie_v[K_FALL]   = ie_fall;
  assign ie_v[K_OC]     = ie_oc;

  for (genvar k = 0; k < NKIND; k++) begin : g_stat
    always_comb st_n[k] = (st_q[k] & ~clr_v[k]) | set_v[k];

    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) st_q[k] <= '0;
      else        st_q[k] <= st_n[k];
    end
  end

  assign fault_st = st_q[K_FAULT];
  assign rise_st  = st_q[K_RISE];
  assign fall_st  = st_q[K_FALL];
  assign oc_st    = st_q[K_OC];
  assign irq      = |(st_q & ie_v);

  p_off_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (!bit_en && clr_v == '0) |=> $stable(st_q));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (set_v != '0) |=> ((st_q & $past(set_v)) == $past(set_v)));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (ie_v == '0) |-> !irq);
endmodule

// File: tb/chan_bit_monitor_test.sv
module chan_bit_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 16;
  localparam int DW  = 4;
  localparam int LIM = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_en;
  logic [N-1:0] ch_dir, ch_out, ch_in;
  logic cmp_in;
  logic [N-1:0] ie_fault, ie_rise, ie_fall, ie_oc;
  logic [N-1:0] clr_fault, clr_rise, clr_fall, clr_oc;
  logic [3:0]   cmp_sel;
  logic [N-1:0] fault_st, rise_st, fall_st, oc_st;
  logic irq;
  logic [N-1:0] inj;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // reference model state
  int m_sel, m_dwell, m_rcnt;
  int m_run [N];
  logic [N-1:0] m_prev, m_fault, m_rise, m_fall, m_oc;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_bit_monitor #(.NCH(N), .SETTLE(DW), .CLK_MHZ(1), .OC_US(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ch_dir(ch_dir), .ch_out(ch_out),
    .ch_in(ch_in), .cmp_in(cmp_in), .ie_fault(ie_fault), .ie_rise(ie_rise),
    .ie_fall(ie_fall), .ie_oc(ie_oc), .clr_fault(clr_fault), .clr_rise(clr_rise),
    .clr_fall(clr_fall), .clr_oc(clr_oc), .cmp_sel(cmp_sel), .fault_st(fault_st),
    .rise_st(rise_st), .fall_st(fall_st), .oc_st(oc_st), .irq(irq)
  );

  function automatic logic expect_lvl(int s);
    return ch_dir[s] ? ch_out[s] : ch_in[s];
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] sf, sr, sd, so;
    sf = '0; sr = '0; sd = '0; so = '0;
    if (!rst_n) begin
      m_sel = 0; m_dwell = 0; m_rcnt = 0; m_prev = '0;
      m_fault = '0; m_rise = '0; m_fall = '0; m_oc = '0;
      for (int i = 0; i < N; i++) m_run[i] = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      if (bit_en) begin
        if (m_dwell == DW - 1) begin
          if (cmp_in != expect_lvl(m_sel)) sf[m_sel] = 1'b1;
          m_sel = (m_sel + 1) % N;
          m_dwell = 0;
        end else m_dwell++;
      end else begin
        m_sel = 0; m_dwell = 0;
      end
      for (int i = 0; i < N; i++) begin
        if (bit_en && ch_in[i] && !m_prev[i]) sr[i] = 1'b1;
        if (bit_en && !ch_in[i] && m_prev[i]) sd[i] = 1'b1;
        if (bit_en && ch_dir[i] && (ch_in[i] != ch_out[i])) m_run[i]++;
        else m_run[i] = 0;
        if (m_run[i] > LIM) so[i] = 1'b1;
      end
      m_prev  = ch_in;
      m_fault = (m_fault & ~clr_fault) | sf;
      m_rise  = (m_rise & ~clr_rise) | sr;
      m_fall  = (m_fall & ~clr_fall) | sd;
      m_oc    = (m_oc & ~clr_oc) | so;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic m_irq;
    m_irq = |((m_fault & ie_fault) | (m_rise & ie_rise) | (m_fall & ie_fall) | (m_oc & ie_oc));
    chk("R2", "cmp_sel", 32'(cmp_sel), 32'(m_sel));
    chk("R3", "fault_st", 32'(fault_st), 32'(m_fault));
    chk("R4", "rise_st", 32'(rise_st), 32'(m_rise));
    chk("R4", "fall_st", 32'(fall_st), 32'(m_fall));
    chk("R5", "oc_st", 32'(oc_st), 32'(m_oc));
    chk("R8", "irq", 32'(irq), 32'(m_irq));
  endtask

  task automatic cycle();
    cmp_in = expect_lvl(m_sel) ^ inj[m_sel];
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic cycles(int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic no_clear();
    clr_fault = '0; clr_rise = '0; clr_fall = '0; clr_oc = '0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [N-1:0] snap_f, snap_r;
    rst_n = 1'b0; bit_en = 1'b0; ch_dir = 16'hF0F0; ch_out = 16'h50A0;
    ch_in = 16'h0000; cmp_in = 1'b0; inj = '0;
    ie_fault = '0; ie_rise = '0; ie_fall = '0; ie_oc = '0; no_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cycles(4);
    // R1: reset state
    chk("R1", "status after reset", 32'({fault_st | rise_st | fall_st | oc_st}), 32'h0);
    chk("R1", "irq/sel after reset", 32'({irq, cmp_sel}), 32'h0);

    // outputs read back their driven level, inputs stay low
    ch_in = ch_out & ch_dir;
    cycles(2);
    clr_rise = '1; clr_fall = '1; cycle(); no_clear(); cycle();
    bit_en = 1'b1;
    cycles(2 * N * DW);
    chk("R3", "clean sweeps leave no fault", 32'(fault_st), 32'h0);

    // R3: comparator disagrees on channels 3 (input) and 12 (output)
    inj = 16'h1008;
    cycles(N * DW + 2);
    inj = '0;
    cycles(N * DW);
    chk("R3", "injected faults", 32'(fault_st), 32'h1008);

    // R4: input channel 1 rises, then falls
    ch_in[1] = 1'b1; cycle();
    chk("R4", "rise ch1", 32'(rise_st[1]), 32'h1);
    ch_in[1] = 1'b0; cycle();
    chk("R4", "fall ch1", 32'(fall_st[1]), 32'h1);

    // R5: output ch4 mismatched for exactly LIM cycles -> no flag
    ch_in[4] = ~ch_out[4];
    cycles(LIM);
    chk("R5", "oc at limit", 32'(oc_st[4]), 32'h0);
    ch_in[4] = ch_out[4]; cycle();
    ch_in[4] = ~ch_out[4];
    cycles(LIM);
    chk("R5", "oc after restart", 32'(oc_st[4]), 32'h0);
    cycle();
    chk("R5", "oc after limit+1", 32'(oc_st[4]), 32'h1);
    ch_in[4] = ch_out[4]; cycle();
    // input channel 2 never flags over-current
    ch_in[2] = 1'b1; cycles(LIM + 3); ch_in[2] = 1'b0; cycle();
    chk("R5", "input ch no oc", 32'(oc_st[2]), 32'h0);

    // R8: masks
    ie_oc = 16'h0010; cycle();
    chk("R8", "irq from oc", 32'(irq), 32'h1);
    ie_oc = 16'h0001; cycle();
    chk("R8", "irq masked", 32'(irq), 32'h0);
    ie_fault = 16'h1000; cycle();
    chk("R8", "irq from fault", 32'(irq), 32'h1);
    ie_fault = '0; ie_oc = '0;

    // R6: clear, and set winning over clear
    clr_fault = 16'h0008; clr_oc = '1; cycle(); no_clear(); cycle();
    chk("R6", "partial clear", 32'({fault_st, oc_st}), 32'h1000_0000);
    ch_in[1] = 1'b1; clr_rise = 16'h0002; cycle(); no_clear();
    chk("R6", "set beats clear", 32'(rise_st[1]), 32'h1);
    cycle();
    chk("R6", "sticky", 32'(rise_st[1]), 32'h1);

    // R7: disabled -> nothing new, sel parked
    bit_en = 1'b0; cycle();
    snap_f = fault_st; snap_r = rise_st;
    inj = '1; ch_in[1] = 1'b0; ch_in[0] = 1'b1; ch_in[5] = ~ch_out[5];
    cycles(LIM + N * DW);
    chk("R7", "fault hold", 32'(fault_st), 32'(snap_f));
    chk("R7", "rise hold", 32'(rise_st), 32'(snap_r));
    chk("R7", "oc hold", 32'(oc_st), 32'h0);
    chk("R2", "sel parked", 32'(cmp_sel), 32'h0);
    inj = '0; ch_in[5] = ch_out[5];
    bit_en = 1'b1;
    cycles(3 * DW);
    chk("R2", "dwell restarts", 32'(cmp_sel), 32'h3);

    // random traffic, compared every clock
    for (int k = 0; k < 3000; k++) begin
      if ((k % 200) == 0) bit_en = ($urandom_range(0, 3) != 0);
      if ((k % 50) == 0) ch_dir = 16'($urandom);
      if ((k % 7) == 0) ch_out = 16'($urandom);
      ch_in = ($urandom_range(0, 7) == 0) ? 16'($urandom) : (ch_out & ch_dir);
      inj = ($urandom_range(0, 15) == 0) ? 16'($urandom) : '0;
      ie_fault = 16'($urandom); ie_rise = 16'($urandom);
      ie_fall = 16'($urandom); ie_oc = 16'($urandom);
      clr_fault = ($urandom_range(0, 9) == 0) ? 16'($urandom) : '0;
      clr_rise  = ($urandom_range(0, 9) == 0) ? 16'($urandom) : '0;
      clr_fall  = ($urandom_range(0, 9) == 0) ? 16'($urandom) : '0;
      clr_oc    = ($urandom_range(0, 30) == 0) ? 16'($urandom) : '0;
      cycle();
    end
    no_clear();
    cycle();
    summary();
  end
endmodule